// File: doc/BRIEF.md
# Clock Source Enable and Switch Controller

This block is the control side of a system clock tree. It keeps one 8-bit configuration register that turns the oscillator sources on. There are two internal RC oscillators, one fast and one slow, and one external source with three wiring modes. The block also decides which source drives the system clock. Software can change the register only through a timed-access unlock: two key bytes written to an access port in back-to-back cycles open a short window, and one configuration write may land inside it.

Hardware can override what software wrote. Several always-on subsystems need the slow RC oscillator: the watchdog, the wake-up timer when it runs from that RC, the brown-out detector and the reset filter. While any of them is active, the slow RC cannot be switched off. While in-application programming is active, the fast RC is forced on and reported stable. When that ends, the value software last wrote shows again. A request to move the system clock to a source that is not enabled and stable does not complete. The request is held, a sticky fault flag is raised, and the switch happens by itself once the target becomes ready.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, the register reads 8'h30, the selected source is the fast RC (code 0), the enables read 3'b011 ({external, slow RC, fast RC}) and the fault flag is 0.
- R2: Writing 8'hAA and then 8'h55 to the access port in consecutive cycles opens a window that covers the next 4 cycles. One configuration write in that window is accepted and closes it. Any other key order opens nothing.
- R3: A configuration write made while no window is open leaves the register and all enables unchanged.
- R4: Register bits 3:1 always read 0, whatever is written to them.
- R5: Bits 7:6 select the external source: 00 off (pins stay general purpose), 01 crystal, 10 clock on the crystal-input pin, 11 clock on the dedicated clock pin. The value drives ext_mode, and the external enable is 1 for any nonzero code.
- R6: While the watchdog, the wake-up timer on the slow RC, the brown-out detector or the reset filter is active, a write of 0 to bit 4 is ignored, and bit 4 and the slow-RC enable read 1.
- R7: While in-application programming is active, bit 5, the fast-RC enable and the fast-RC ready status read 1. Afterwards they show the written bit and the real stable input again.
- R8: Source codes are 0 fast RC, 1 slow RC, 2 external, 3 none. A switch request to an enabled and stable source updates sel_src one cycle later and clears the fault flag (bit 0).
- R9: A switch request to a source that is disabled or unstable, or to code 3, sets the fault flag one cycle later and leaves sel_src unchanged.
- R10: A held request completes one cycle after its target first becomes enabled and stable. sel_src then takes the target and the fault flag clears. A held request to code 3 never completes.
- R11: A new switch request replaces any held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr | input | 1 | Write strobe of the access (key) port |
| acc_wdata | input | 8 | Key byte |
| cfg_wr | input | 1 | Write strobe of the configuration register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Register read value including hardware overrides |
| iap_en | input | 1 | In-application programming active |
| wdt_en | input | 1 | Watchdog enabled |
| wkt_on_slow | input | 1 | Wake-up timer running from the slow RC |
| bod_en | input | 1 | Brown-out detector enabled |
| rstf_en | input | 1 | Reset filter enabled |
| src_stable | input | 3 | Stable status {external, slow RC, fast RC} |
| sw_req | input | 1 | Switch request strobe |
| sw_target | input | 2 | Requested source code |
| src_en | output | 3 | Oscillator enables {external, slow RC, fast RC} |
| ext_mode | output | 2 | External source mode |
| fast_rdy | output | 1 | Fast RC ready status |
| sel_src | output | 2 | Selected system clock source |
| sw_fault | output | 1 | Sticky switch fault flag |

## Verification
The override outputs (cfg_rdata bits 5 and 4, src_en, fast_rdy) follow the lock and programming inputs combinationally, in the same cycle. A key write or configuration write shows in cfg_rdata and the enables one edge after its strobe. A switch request or a newly ready pending target shows in sel_src and the fault flag one edge after the cycle in which it is seen. The bench drives each stimulus just after a falling edge. It moves its reference model forward at the next rising edge and compares every output at the falling edge after that, so each result is sampled in the cycle it is due.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  localparam int NUM_SRC   = 3;
  localparam int NUM_CODES = 4;

  localparam logic [7:0] TA_KEY1 = 8'hAA;
  localparam logic [7:0] TA_KEY2 = 8'h55;

  localparam int EXT_HI    = 7;
  localparam int EXT_LO    = 6;
  localparam int FAST_BIT  = 5;
  localparam int SLOW_BIT  = 4;
  localparam int FAULT_BIT = 0;

  // Read value: reserved bits are tied low.
  function automatic logic [7:0] pack_status(input logic [1:0] ext,
                                             input logic fast,
                                             input logic slow,
                                             input logic fault);
    logic [7:0] r;
    r = '0;
    r[EXT_HI:EXT_LO] = ext;
    r[FAST_BIT]      = fast;
    r[SLOW_BIT]      = slow;
    r[FAULT_BIT]     = fault;
    return r;
  endfunction

  // Next value of the slow-RC bit under the lock rule.
  function automatic logic slow_next(input logic cur, input logic wbit,
                                     input logic locked);
    return (locked && !wbit) ? cur : wbit;
  endfunction

endpackage

// File: rtl/ta_gate.sv
module ta_gate
  import clk_src_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic [7:0] acc_wdata,
  input  logic       cfg_wr,
  output logic       win_open,
  output logic       unlock_hit,
  output logic       wr_accept
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_CYCLES);

  logic          key1_seen;
  logic [CW-1:0] win_cnt;
  logic          key1_hit;

  assign key1_hit   = acc_wr && (acc_wdata == TA_KEY1);
  assign unlock_hit = acc_wr && (acc_wdata == TA_KEY2) && key1_seen;
  assign win_open   = (win_cnt != '0);
  assign wr_accept  = cfg_wr && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key1_seen <= 1'b0;
      win_cnt   <= '0;
    end else begin
      key1_seen <= key1_hit;
      if (unlock_hit)     win_cnt <= WIN_LOAD;
      else if (wr_accept) win_cnt <= '0;
      else if (win_open)  win_cnt <= win_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/src_cfg_reg.sv
module src_cfg_reg
  import clk_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_accept,
  input  logic [7:0] wdata,
  input  logic       slow_lock,
  output logic [1:0] ext_q,
  output logic       fast_q,
  output logic       slow_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 2'b00;
      fast_q <= 1'b1;
      slow_q <= 1'b1;
    end else if (wr_accept) begin
      ext_q  <= wdata[EXT_HI:EXT_LO];
      fast_q <= wdata[FAST_BIT];
      slow_q <= slow_next(slow_q, wdata[SLOW_BIT], slow_lock);
    end
  end
endmodule

// File: rtl/clk_switch.sv
module clk_switch
  import clk_src_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_req,
  input  logic [1:0]           sw_target,
  input  logic [NUM_CODES-1:0] ready_vec,
  output logic [1:0]           sel_src,
  output logic                 sw_fault,
  output logic                 pend_resolve
);
  logic pend_q;
  src_e pend_tgt;
  src_e sel_q;
  src_e req_tgt;

  assign req_tgt      = src_e'(sw_target);
  assign pend_resolve = pend_q && ready_vec[pend_tgt] && !sw_req;
  assign sel_src      = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SRC_FAST;
      sw_fault <= 1'b0;
      pend_q   <= 1'b0;
      pend_tgt <= SRC_FAST;
    end else if (sw_req) begin
      if (ready_vec[req_tgt]) begin
        sel_q    <= req_tgt;
        sw_fault <= 1'b0;
        pend_q   <= 1'b0;
      end else begin
        sw_fault <= 1'b1;
        pend_q   <= 1'b1;
        pend_tgt <= req_tgt;
      end
    end else if (pend_resolve) begin
      sel_q    <= pend_tgt;
      sw_fault <= 1'b0;
      pend_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_wr,
  input  logic [7:0]   acc_wdata,
  input  logic         cfg_wr,
  input  logic [7:0]   cfg_wdata,
  output logic [7:0]   cfg_rdata,
  input  logic         iap_en,
  input  logic         wdt_en,
  input  logic         wkt_on_slow,
  input  logic         bod_en,
  input  logic         rstf_en,
  input  logic [2:0]   src_stable,
  input  logic         sw_req,
  input  logic [1:0]   sw_target,
  output logic [2:0]   src_en,
  output logic [1:0]   ext_mode,
  output logic         fast_rdy,
  output logic [1:0]   sel_src,
  output logic         sw_fault
);
  logic       win_open, unlock_hit, wr_accept;
  logic [1:0] ext_q;
  logic       fast_q, slow_q;
  logic       slow_lock;
  logic [NUM_SRC-1:0]   stab_eff;
  logic [NUM_CODES-1:0] ready_vec;
  logic       tgt_ready;
  logic       pend_resolve;

  assign slow_lock = wdt_en | wkt_on_slow | bod_en | rstf_en;

  ta_gate #(.WIN_CYCLES(WIN_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .cfg_wr(cfg_wr), .win_open(win_open), .unlock_hit(unlock_hit),
    .wr_accept(wr_accept)
  );

  src_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wdata(cfg_wdata),
    .slow_lock(slow_lock), .ext_q(ext_q), .fast_q(fast_q), .slow_q(slow_q)
  );

  assign src_en[SRC_FAST] = fast_q | iap_en;
  assign src_en[SRC_SLOW] = slow_q | slow_lock;
  assign src_en[SRC_EXT]  = |ext_q;
  assign fast_rdy         = src_stable[SRC_FAST] | iap_en;
  assign stab_eff         = {src_stable[SRC_EXT], src_stable[SRC_SLOW], fast_rdy};
  assign ext_mode         = ext_q;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_ready
    if (i < NUM_SRC) begin : g_real
      assign ready_vec[i] = src_en[i] & stab_eff[i];
    end else begin : g_none
      assign ready_vec[i] = 1'b0;
    end
  end

  assign tgt_ready = ready_vec[sw_target];

  clk_switch u_sw (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_target(sw_target),
    .ready_vec(ready_vec), .sel_src(sel_src), .sw_fault(sw_fault),
    .pend_resolve(pend_resolve)
  );

  assign cfg_rdata = pack_status(ext_q, src_en[SRC_FAST], src_en[SRC_SLOW], sw_fault);
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic [2:0] src_en,
  input logic       fast_rdy,
  input logic       iap_en,
  input logic       slow_lock,
  input logic       wr_accept,
  input logic       win_open,
  input logic       unlock_hit,
  input logic [1:0] ext_q,
  input logic       fast_q,
  input logic       sw_req,
  input logic [1:0] sw_target,
  input logic       tgt_ready,
  input logic       pend_resolve,
  input logic [1:0] sel_src,
  input logic       sw_fault
);
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:1] == 3'b000);

  a_r6_slow_locked: assert property (@(posedge clk) disable iff (!rst_n)
    slow_lock |-> (cfg_rdata[4] && src_en[1]));

  a_r7_iap_force: assert property (@(posedge clk) disable iff (!rst_n)
    iap_en |-> (cfg_rdata[5] && src_en[0] && fast_rdy));

  a_r3_dropped_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> ($stable(ext_q) && $stable(fast_q)));

  a_r2_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !unlock_hit) |=> !win_open);

  a_r8_switch_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && tgt_ready) |=> (sel_src == $past(sw_target) && !sw_fault));

  a_r9_switch_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !tgt_ready) |=> (sw_fault && $stable(sel_src)));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fault && !sw_req && !pend_resolve) |=> sw_fault);
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .src_en(src_en),
  .fast_rdy(fast_rdy), .iap_en(iap_en), .slow_lock(slow_lock),
  .wr_accept(wr_accept), .win_open(win_open), .unlock_hit(unlock_hit),
  .ext_q(ext_q), .fast_q(fast_q), .sw_req(sw_req), .sw_target(sw_target),
  .tgt_ready(tgt_ready), .pend_resolve(pend_resolve), .sel_src(sel_src),
  .sw_fault(sw_fault)
);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       iap_en = 1'b0, wdt_en = 1'b0, wkt_on_slow = 1'b0, bod_en = 1'b0, rstf_en = 1'b0;
  logic [2:0] src_stable = 3'b111;
  logic       sw_req = 1'b0;
  logic [1:0] sw_target = '0;
  logic [2:0] src_en;
  logic [1:0] ext_mode;
  logic       fast_rdy;
  logic [1:0] sel_src;
  logic       sw_fault;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [1:0] m_ext;
  logic m_fast, m_slow, m_aa, m_fault, m_pend;
  logic [1:0] m_sel, m_ptgt;
  int m_win;

  always #5 clk = ~clk;

  clk_src_ctrl u_dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic locked();
    return wdt_en | wkt_on_slow | bod_en | rstf_en;
  endfunction

  function automatic logic [2:0] exp_en();
    return {m_ext != 2'b00, m_slow | locked(), m_fast | iap_en};
  endfunction

  function automatic logic src_ok(input logic [1:0] s);
    logic [2:0] en, st;
    en = exp_en();
    st = {src_stable[2], src_stable[1], src_stable[0] | iap_en};
    if (s == 2'd3) return 1'b0;
    return en[s] & st[s];
  endfunction

  task automatic compare_all();
    check("R5 ext field", {6'b0, cfg_rdata[7:6]}, {6'b0, m_ext});
    check("R7 fast bit", {7'b0, cfg_rdata[5]}, {7'b0, m_fast | iap_en});
    check("R6 slow bit", {7'b0, cfg_rdata[4]}, {7'b0, m_slow | locked()});
    check("R4 reserved", {5'b0, cfg_rdata[3:1]}, 8'h00);
    check("R9 fault", {7'b0, sw_fault}, {7'b0, m_fault});
    check("R5 enables", {5'b0, src_en}, {5'b0, exp_en()});
    check("R5 ext_mode", {6'b0, ext_mode}, {6'b0, m_ext});
    check("R7 fast_rdy", {7'b0, fast_rdy}, {7'b0, src_stable[0] | iap_en});
    check("R8 sel_src", {6'b0, sel_src}, {6'b0, m_sel});
  endtask

  // Advance one clock: model next state from the inputs now applied.
  task automatic step();
    logic [1:0] n_ext, n_sel, n_ptgt;
    logic n_fast, n_slow, n_aa, n_fault, n_pend, acc;
    int n_win;
    acc = cfg_wr && (m_win > 0);
    n_ext = m_ext; n_fast = m_fast; n_slow = m_slow;
    if (acc) begin
      n_ext  = cfg_wdata[7:6];
      n_fast = cfg_wdata[5];
      n_slow = (locked() && !cfg_wdata[4]) ? m_slow : cfg_wdata[4];
    end
    if (acc_wr && acc_wdata == 8'h55 && m_aa) n_win = 4;
    else if (acc) n_win = 0;
    else if (m_win > 0) n_win = m_win - 1;
    else n_win = 0;
    n_aa = acc_wr && acc_wdata == 8'hAA;
    n_sel = m_sel; n_fault = m_fault; n_pend = m_pend; n_ptgt = m_ptgt;
    if (sw_req) begin
      if (src_ok(sw_target)) begin n_sel = sw_target; n_fault = 0; n_pend = 0; end
      else begin n_fault = 1; n_pend = 1; n_ptgt = sw_target; end
    end else if (m_pend && src_ok(m_ptgt)) begin
      n_sel = m_ptgt; n_fault = 0; n_pend = 0;
    end
    @(posedge clk);
    @(negedge clk);
    m_ext = n_ext; m_fast = n_fast; m_slow = n_slow; m_win = n_win; m_aa = n_aa;
    m_sel = n_sel; m_fault = n_fault; m_pend = n_pend; m_ptgt = n_ptgt;
    compare_all();
    acc_wr = 0; cfg_wr = 0; sw_req = 0;
  endtask

  task automatic key(input logic [7:0] d);
    acc_wr = 1; acc_wdata = d; step();
  endtask

  task automatic raw_write(input logic [7:0] d);
    cfg_wr = 1; cfg_wdata = d; step();
  endtask

  task automatic prot_write(input logic [7:0] d);
    key(8'hAA); key(8'h55); raw_write(d);
  endtask

  task automatic request(input logic [1:0] t);
    sw_req = 1; sw_target = t; step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_ext = 0; m_fast = 1; m_slow = 1; m_aa = 0; m_fault = 0; m_pend = 0;
    m_sel = 0; m_ptgt = 0; m_win = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    check("R1 reset rdata", cfg_rdata, 8'h30);
    check("R1 reset sel", {6'b0, sel_src}, 8'h00);
    check("R1 reset en", {5'b0, src_en}, 8'h03);
    compare_all();

    // R3 unprotected write dropped
    raw_write(8'hC0);
    check("R3 dropped", cfg_rdata, 8'h30);
    // R2 non-consecutive keys open nothing
    key(8'hAA); step(); key(8'h55); raw_write(8'h40);
    check("R2 gap keys", cfg_rdata, 8'h30);
    key(8'h55); key(8'hAA); raw_write(8'h40);
    check("R2 order keys", cfg_rdata, 8'h30);

    // R5, R4 every external encoding, reserved bits written as 1
    for (int c = 0; c < 4; c++) begin
      prot_write({c[1:0], 2'b11, 3'b111, 1'b1});
      check("R5 ext_mode", {6'b0, ext_mode}, {6'b0, c[1:0]});
      check("R4 reserved", {5'b0, cfg_rdata[3:1]}, 8'h00);
    end

    // R2 window length and single use
    key(8'hAA); key(8'h55); idle(4); raw_write(8'h70);
    check("R2 expired", cfg_rdata[7:6], 8'd3);
    key(8'hAA); key(8'h55); idle(3); raw_write(8'h70);
    check("R2 last slot", {6'b0, cfg_rdata[7:6]}, 8'd1);
    key(8'hAA); key(8'h55); raw_write(8'hB0); raw_write(8'h30);
    check("R2 one write", {6'b0, cfg_rdata[7:6]}, 8'd2);

    // R6 each lock condition
    for (int i = 0; i < 4; i++) begin
      {wdt_en, wkt_on_slow, bod_en, rstf_en} = 4'b1000 >> i;
      prot_write(8'h20);
      check("R6 locked read", {7'b0, cfg_rdata[4]}, 8'h01);
      {wdt_en, wkt_on_slow, bod_en, rstf_en} = 4'b0000;
      step();
      check("R6 write ignored", {7'b0, cfg_rdata[4]}, 8'h01);
    end
    prot_write(8'h20);
    check("R6 unlocked clear", {7'b0, src_en[1]}, 8'h00);
    bod_en = 1; step();
    check("R6 forced", {7'b0, src_en[1]}, 8'h01);
    bod_en = 0; prot_write(8'h30);

    // R7 force and restore
    prot_write(8'h10); src_stable[0] = 0; step();
    check("R7 off", {7'b0, cfg_rdata[5]}, 8'h00);
    iap_en = 1; step();
    check("R7 forced", {6'b0, cfg_rdata[5], fast_rdy}, 8'h03);
    iap_en = 0; step();
    check("R7 restored", {6'b0, cfg_rdata[5], fast_rdy}, 8'h00);
    src_stable[0] = 1;

    // R8 / R9 / R10 / R11
    prot_write(8'h50);
    request(2'd2);
    check("R8 to ext", {6'b0, sel_src}, 8'd2);
    request(2'd0);
    check("R9 disabled", {7'b0, sw_fault}, 8'h01);
    prot_write(8'h70); step();
    check("R10 resolved", {6'b0, sel_src}, 8'd0);
    src_stable[1] = 0; request(2'd1); idle(3);
    check("R9 pending", {6'b0, sel_src, sw_fault}, 8'h01);
    src_stable[1] = 1; step();
    check("R10 stable now", {5'b0, sel_src, sw_fault}, 8'h02);
    src_stable[1] = 0; request(2'd1); request(2'd2);
    src_stable[1] = 1; idle(2);
    check("R11 replaced", {6'b0, sel_src}, 8'd2);
    request(2'd3); idle(3);
    check("R10 none stays", {7'b0, sw_fault}, 8'h01);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 16;
      if ($urandom % 16 == 0) {wdt_en, wkt_on_slow, bod_en, rstf_en} = 4'($urandom);
      if ($urandom % 16 == 0) iap_en = ~iap_en;
      if ($urandom % 8 == 0) src_stable = 3'($urandom);
      if (r == 0) prot_write(8'($urandom));
      else if (r == 1) key(8'hAA);
      else if (r == 2) key(8'h55);
      else if (r == 3) raw_write(8'($urandom));
      else if (r < 7) request(2'($urandom));
      else step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule